// File: doc/BRIEF.md
# Throttled Read Completion Transmitter

This block turns a single-dword read request into a completion packet for a link core whose transmit port moves one 32-bit beat per cycle under a valid/ready handshake with start and end flags. When it accepts a request it latches the requester identity, tag, byte count and target address. It then starts a read cycle on a slow local bus and, in parallel, begins streaming the three header dwords of the completion. If the target has not answered by the time the data beat is due, the block drops the source-valid signal and holds the packet open with wait states until the data arrives.

A watchdog counts local-bus wait cycles. If the target does not answer within the configured limit, the read is abandoned and the completion still goes out, with an all-ones data word, so that the requester never hangs. A timeout also raises a one-cycle interrupt request. It also sets a sticky status bit that software can poll, because the interrupt may reach software after the next request has already been issued. A write-one-to-clear strobe clears the status bit.

Top module: `rdcpl_tx`

## Requirements
- R1: The completion has four beats in this order. Beat 0 is the fixed word 32'h4A000001. Beat 1 is {CPL_ID[15:0], 4'b0000, byteCnt[11:0]}. Beat 2 is {reqId[15:0], tag[7:0], 8'h00}. Beat 3 is the read data. reqId, tag and byteCnt are the values latched when the request was accepted.
- R2: txSop is high exactly on beat 0 and txEop exactly on beat 3, in each case only while txValid is high. A beat advances only in a cycle where txValid and txReady are both high. While txValid is high and txReady is low, txValid and txData stay unchanged.
- R3: Header beats are offered from the cycle after acceptance without waiting for the bus. txValid stays low at beat 3, for as many cycles as needed, until bus data or a timeout is available.
- R4: After the end-of-packet beat is transferred, txValid is low for at least one cycle before the next packet starts.
- R5: busRd is high from the cycle after acceptance until the cycle in which busAck is seen, inclusive. busAddr carries the latched request address.
- R6: If busAck has not been seen after TIMEOUT_CYC cycles of busRd, busRd drops and the data beat is 32'hFFFFFFFF.
- R7: A timeout produces an irqReq pulse exactly one cycle long, in the first cycle after busRd drops. No irqReq occurs on a read that completes normally.
- R8: statusTimeout is set by a timeout and remains set until a cycle in which statusClr is high. If a timeout and statusClr fall in the same cycle, the bit ends up set.
- R9: reqReady is high only when the block is idle. It stays low from acceptance until the end-of-packet beat has been transferred.
- R10: A busAck in the last allowed watchdog cycle counts as a normal response: the real data is returned and there is no interrupt.
- R11: During and directly after reset, reqReady is 1 and txValid, busRd, irqReq and statusTimeout are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request offered |
| reqReady | output | 1 | Block can accept a request |
| reqReqId | input | 16 | Requester identity |
| reqTag | input | 8 | Request tag |
| reqByteCnt | input | 12 | Byte count for the completion header |
| reqAddr | input | ADDR_W | Local-bus target address |
| busRd | output | 1 | Local-bus read cycle in progress |
| busAddr | output | ADDR_W | Latched local-bus address |
| busAck | input | 1 | Target returns data this cycle |
| busData | input | 32 | Target read data |
| txValid | output | 1 | Transmit beat valid (source-valid throttle) |
| txSop | output | 1 | First beat of packet |
| txEop | output | 1 | Last beat of packet |
| txData | output | 32 | Transmit beat data |
| txReady | input | 1 | Link core accepts the beat |
| irqReq | output | 1 | One-cycle interrupt request on timeout |
| statusTimeout | output | 1 | Sticky timeout status |
| statusClr | input | 1 | Write-one-to-clear strobe for the status |

## Verification
Two functions can meet in one cycle. The watchdog can set the sticky status in the same cycle that software's clear strobe arrives, and a late busAck can coincide with the final watchdog cycle. The bench provokes the first case by raising statusClr in the last wait cycle of a read that times out, and judges it by reading statusTimeout as still set once the completion has gone out. It provokes the second case with an acknowledge placed exactly on the last allowed cycle, and judges it by real data on the data beat and by no interrupt pulse.

// File: rtl/rdcpl_pkg.sv
package rdcpl_pkg;

  localparam logic [31:0] CPL_HDR0  = 32'h4A00_0001;
  localparam logic [1:0]  LAST_BEAT = 2'd3;

  typedef enum logic {ST_IDLE, ST_ACTIVE} rdState_e;

  typedef struct packed {
    logic capReq;
    logic capData;
    logic forceOnes;
    logic beatAdv;
  } ctrlStrb_t;

endpackage

// File: rtl/rdcpl_dpath.sv
module rdcpl_dpath
  import rdcpl_pkg::*;
#(
  parameter int          ADDR_W = 16,
  parameter logic [15:0] CPL_ID = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [15:0]       reqReqId,
  input  logic [7:0]        reqTag,
  input  logic [11:0]       reqByteCnt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       busData,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       txData,
  output logic [1:0]        beatIdx
);

  logic [15:0]       ridQ;
  logic [7:0]        tagQ;
  logic [11:0]       bcQ;
  logic [ADDR_W-1:0] addrQ;
  logic [31:0]       dataQ;
  logic [1:0]        beatQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ridQ  <= '0;
      tagQ  <= '0;
      bcQ   <= '0;
      addrQ <= '0;
    end else if (strb.capReq) begin
      ridQ  <= reqReqId;
      tagQ  <= reqTag;
      bcQ   <= reqByteCnt;
      addrQ <= reqAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataQ <= '0;
    else if (strb.forceOnes) dataQ <= '1;
    else if (strb.capData)   dataQ <= busData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             beatQ <= '0;
    else if (strb.capReq)  beatQ <= '0;
    else if (strb.beatAdv) beatQ <= beatQ + 2'd1;
  end

  always_comb begin
    case (beatQ)
      2'd0:    txData = CPL_HDR0;
      2'd1:    txData = {CPL_ID, 4'h0, bcQ};
      2'd2:    txData = {ridQ, tagQ, 8'h00};
      default: txData = dataQ;
    endcase
  end

  assign busAddr = addrQ;
  assign beatIdx = beatQ;

  AST_CAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.capReq && strb.beatAdv)); // R9

endmodule

// File: rtl/rdcpl_ctrl.sv
module rdcpl_ctrl
  import rdcpl_pkg::*;
#(
  parameter int TIMEOUT_CYC = 250
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      busAck,
  output logic      busRd,
  input  logic      txReady,
  output logic      txValid,
  output logic      txSop,
  output logic      txEop,
  input  logic [1:0] beatIdx,
  output logic      irqReq,
  output logic      statusTimeout,
  input  logic      statusClr,
  output ctrlStrb_t strb
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(TIMEOUT_CYC - 1);

  rdState_e        state;
  logic            busPend, dataRdy, irqQ, stickyQ;
  logic [CNT_W-1:0] wdCnt;
  logic            accept, hdrLeft, fire, done, ackHit, tmo;

  always_comb begin
    reqReady       = (state == ST_IDLE);
    accept         = reqReady && reqValid;
    hdrLeft        = (beatIdx != LAST_BEAT);
    txValid        = (state == ST_ACTIVE) && (hdrLeft || dataRdy);
    txSop          = txValid && (beatIdx == 2'd0);
    txEop          = txValid && !hdrLeft;
    fire           = txValid && txReady;
    done           = fire && !hdrLeft;
    ackHit         = busPend && busAck;
    tmo            = busPend && !busAck && (wdCnt == LAST_WAIT);
    strb.capReq    = accept;
    strb.capData   = ackHit;
    strb.forceOnes = tmo;
    strb.beatAdv   = fire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      busPend <= 1'b0;
      dataRdy <= 1'b0;
      wdCnt   <= '0;
      irqQ    <= 1'b0;
      stickyQ <= 1'b0;
    end else begin
      if (accept)    state <= ST_ACTIVE;
      else if (done) state <= ST_IDLE;

      if (accept)             busPend <= 1'b1;
      else if (ackHit || tmo) busPend <= 1'b0;

      if (accept)             dataRdy <= 1'b0;
      else if (ackHit || tmo) dataRdy <= 1'b1;

      if (accept)       wdCnt <= '0;
      else if (busPend) wdCnt <= wdCnt + 1'b1;

      irqQ <= tmo;

      if (tmo)            stickyQ <= 1'b1;
      else if (statusClr) stickyQ <= 1'b0;
    end
  end

  assign busRd         = busPend;
  assign irqReq        = irqQ;
  assign statusTimeout = stickyQ;

  AST_EOP_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txEop) |=> !txValid); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq); // R7
  AST_IRQ_AFTER_BUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $fell(busRd)); // R7
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R9
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (statusTimeout && !statusClr) |=> statusTimeout); // R8
  AST_WD_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    busRd |-> (wdCnt < CNT_W'(TIMEOUT_CYC))); // R6
  AST_SOP_ONLY_BEAT0: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady && txSop) |=> !txSop); // R2

endmodule

// File: rtl/rdcpl_tx.sv
module rdcpl_tx
  import rdcpl_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          TIMEOUT_CYC = 250,
  parameter logic [15:0] CPL_ID      = 16'h0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [15:0]       reqReqId,
  input  logic [7:0]        reqTag,
  input  logic [11:0]       reqByteCnt,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              busRd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busAck,
  input  logic [31:0]       busData,
  output logic              txValid,
  output logic              txSop,
  output logic              txEop,
  output logic [31:0]       txData,
  input  logic              txReady,
  output logic              irqReq,
  output logic              statusTimeout,
  input  logic              statusClr
);

  ctrlStrb_t  strb;
  logic [1:0] beatIdx;

  rdcpl_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .busAck(busAck), .busRd(busRd), .txReady(txReady), .txValid(txValid),
    .txSop(txSop), .txEop(txEop), .beatIdx(beatIdx), .irqReq(irqReq),
    .statusTimeout(statusTimeout), .statusClr(statusClr), .strb(strb)
  );

  rdcpl_dpath #(.ADDR_W(ADDR_W), .CPL_ID(CPL_ID)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqReqId(reqReqId), .reqTag(reqTag),
    .reqByteCnt(reqByteCnt), .reqAddr(reqAddr), .busData(busData),
    .busAddr(busAddr), .txData(txData), .beatIdx(beatIdx)
  );

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData))); // R2

endmodule

// File: tb/rdcpl_tx_bench.sv
module rdcpl_tx_bench;

  localparam int TO = 20;

  typedef struct packed {
    logic [15:0] rid;
    logic [7:0]  tag;
    logic [11:0] bc;
    logic [15:0] addr;
    logic [7:0]  lat;
    logic [31:0] data;
    logic [7:0]  stall;
    logic        clrAtTo;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'h0A01, 8'h11, 12'h004, 16'h0040, 8'd0,  32'h0000_0062, 8'hFF, 1'b0},
    '{16'h0B02, 8'h22, 12'h008, 16'h1234, 8'd5,  32'hDEAD_BEEF, 8'h6B, 1'b0},
    '{16'h0C03, 8'h33, 12'h004, 16'h00F0, 8'd19, 32'h1234_5678, 8'hFF, 1'b0},
    '{16'h0D04, 8'h44, 12'h004, 16'h0200, 8'd30, 32'h5555_AAAA, 8'hFF, 1'b0},
    '{16'h0E05, 8'h55, 12'hFFC, 16'hBEEF, 8'd2,  32'h0BAD_F00D, 8'h33, 1'b0},
    '{16'h0F06, 8'h66, 12'h004, 16'h0300, 8'd40, 32'h7777_0000, 8'hFF, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqReqId = '0;
  logic [7:0]  reqTag = '0;
  logic [11:0] reqByteCnt = '0;
  logic [15:0] reqAddr = '0;
  logic        busRd;
  logic [15:0] busAddr;
  logic        busAck = 1'b0;
  logic [31:0] busData = '0;
  logic        txValid, txSop, txEop;
  logic [31:0] txData;
  logic        txReady = 1'b0;
  logic        irqReq, statusTimeout;
  logic        statusClr = 1'b0;

  int errors = 0;
  int checks = 0;
  int irqSeen = 0;
  bit expSticky = 1'b0;

  always #2 clk = ~clk;

  rdcpl_tx #(.ADDR_W(16), .TIMEOUT_CYC(TO), .CPL_ID(16'h0100)) u_rdcpl_tx (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqReqId(reqReqId), .reqTag(reqTag), .reqByteCnt(reqByteCnt),
    .reqAddr(reqAddr), .busRd(busRd), .busAddr(busAddr), .busAck(busAck),
    .busData(busData), .txValid(txValid), .txSop(txSop), .txEop(txEop),
    .txData(txData), .txReady(txReady), .irqReq(irqReq),
    .statusTimeout(statusTimeout), .statusClr(statusClr)
  );

  always @(negedge clk) if (irqReq) irqSeen++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input vec_t v);
    logic [31:0] exp [4];
    bit tmoExp;
    bit respGiven;
    int irq0;
    int hdrCyc;
    tmoExp = (int'(v.lat) >= TO);
    exp[0] = 32'h4A00_0001;
    exp[1] = {16'h0100, 4'h0, v.bc};
    exp[2] = {v.rid, v.tag, 8'h00};
    exp[3] = tmoExp ? 32'hFFFF_FFFF : v.data;
    respGiven = 1'b0;
    irq0 = irqSeen;
    hdrCyc = -1;
    reqValid = 1'b1; reqReqId = v.rid; reqTag = v.tag; reqByteCnt = v.bc; reqAddr = v.addr;
    chk(reqReady == 1'b1, "R9 ready when idle", {31'd0, reqReady}, 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    chk(busRd == 1'b1, "R5 busRd after accept", {31'd0, busRd}, 32'd1);
    chk(busAddr == v.addr, "R5 busAddr", {16'd0, busAddr}, {16'd0, v.addr});
    fork
      begin
        int n;
        n = 0;
        while (busRd) begin
          if (n == int'(v.lat)) begin busAck = 1'b1; busData = v.data; respGiven = 1'b1; end
          if (n == TO - 1) begin respGiven = 1'b1; if (v.clrAtTo) statusClr = 1'b1; end
          @(negedge clk);
          busAck = 1'b0;
          statusClr = 1'b0;
          n++;
        end
        chk(n == (tmoExp ? TO : int'(v.lat) + 1), "R6 R10 bus cycle count", n, tmoExp ? TO : int'(v.lat) + 1);
        if (tmoExp) chk(irqReq == 1'b1, "R7 irq after busRd drop", {31'd0, irqReq}, 32'd1);
      end
      begin
        int beat;
        int cyc;
        beat = 0;
        cyc = 0;
        while (beat < 4) begin
          txReady = v.stall[cyc % 8];
          if (txValid && beat == 3) chk(respGiven, "R3 data beat waits", {31'd0, txValid}, 32'd0);
          chk(!reqReady, "R9 busy refuse", {31'd0, reqReady}, 32'd0);
          if (txValid && txReady) begin
            chk(txData == exp[beat], "R1 R6 beat data", txData, exp[beat]);
            chk(txSop == (beat == 0), "R2 sop", {31'd0, txSop}, {31'd0, beat == 0});
            chk(txEop == (beat == 3), "R2 eop", {31'd0, txEop}, {31'd0, beat == 3});
            if (beat == 2) hdrCyc = cyc;
            beat++;
          end
          @(negedge clk);
          cyc++;
        end
        txReady = 1'b0;
        chk(!txValid, "R4 idle gap", {31'd0, txValid}, 32'd0);
        chk(reqReady, "R9 release after eop", {31'd0, reqReady}, 32'd1);
        if (v.stall == 8'hFF) chk(hdrCyc == 2, "R3 header streamed early", hdrCyc, 2);
      end
    join
    chk((irqSeen - irq0) == int'(tmoExp), "R7 R10 irq count", irqSeen - irq0, int'(tmoExp));
    if (tmoExp) expSticky = 1'b1;
    chk(statusTimeout == expSticky, "R8 sticky status", {31'd0, statusTimeout}, {31'd0, expSticky});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({reqReady, txValid, busRd, irqReq, statusTimeout} == 5'b10000, "R11 in reset",
        {27'd0, reqReady, txValid, busRd, irqReq, statusTimeout}, 32'h10);
    rstN = 1'b1;
    @(negedge clk);
    chk({reqReady, txValid, busRd, irqReq, statusTimeout} == 5'b10000, "R11 after reset",
        {27'd0, reqReady, txValid, busRd, irqReq, statusTimeout}, 32'h10);

    for (int i = 0; i < 6; i++) run_txn(VECS[i]);

    // R8: lone clear strobe empties the status
    statusClr = 1'b1;
    @(negedge clk);
    statusClr = 1'b0;
    expSticky = 1'b0;
    chk(statusTimeout == 1'b0, "R8 clear strobe", {31'd0, statusTimeout}, 32'd0);
    @(negedge clk);
    chk(statusTimeout == 1'b0 && irqReq == 1'b0, "R8 stays clear",
        {30'd0, statusTimeout, irqReq}, 32'd0);

    // R10 again after clear: last-cycle ack, status must remain clear
    run_txn(VECS[2]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule